// File: doc/BRIEF.md
# 8-bit Expansion Bus Cycle Controller

This block runs single read and write cycles on a byte-wide expansion bus that has a 20-bit address, which covers a 1 MB space. A host raises a request that carries an address, a write byte, a direction bit and a memory-or-I/O select. The block latches the request and puts the address on the bus while a one-clock address strobe is high. It then drives one of four active-low command strobes. From the end of the second command clock onward it samples a channel-ready line once per clock. While that line is low, the command is stretched by whole clocks.

When ready is seen high, the command ends. Read data is taken from the bus on that same edge, and a one-clock done pulse follows in a recovery clock. During the recovery clock the bus is idle. If ready stays low past ten samples, the block sets a sticky timeout flag and ends the cycle anyway. A DMA grant input, accepted only while the bus is idle, raises the address-enable output and holds off processor cycles.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves all four command strobes high, `bus_ale`, `bus_aen`, `rsp_done`, `bus_dout_en` and `timeout_err` low, and `req_ready` high. Reset is the only thing that clears `timeout_err`.
- R2: On the clock after a request is accepted, `bus_ale` is high for exactly one clock and `bus_addr` carries the request address. The address stays unchanged through every command clock of that cycle.
- R3: The strobe is chosen by {`req_io`,`req_write`}: 00 drives `bus_memr_n` low, 01 drives `bus_memw_n` low, 10 drives `bus_ior_n` low and 11 drives `bus_iow_n` low. At most one strobe is low at any time, and none is low while `bus_ale` is high.
- R4: If `bus_chrdy` is high at its first sample, the command lasts exactly 2 clocks. The whole cycle then takes 4 clocks: address, command, command, and recovery.
- R5: `bus_chrdy` is first sampled at the edge that ends the second command clock, and then once at every later edge. Each low sample adds exactly one command clock.
- R6: Ten consecutive low samples followed by a high one give 12 command clocks and no timeout. An eleventh consecutive low sample ends the command after 12 clocks and sets `timeout_err`, which then stays high.
- R7: `rsp_done` is high for exactly one clock, the recovery clock right after the last command clock. In a read cycle, `rsp_rdata` then holds the `bus_din` value present at the edge where the command ended.
- R8: In a write cycle, `bus_dout_en` is high and `bus_dout` equals the write byte from the address clock through the last command clock. `bus_dout_en` is low in every other clock.
- R9: `req_ready` is low from the accepting edge through the recovery clock. It is high again in the clock after the recovery clock if `dma_grant` is low.
- R10: When `dma_grant` is high while the bus is idle, `bus_aen` goes high at the next edge. While `bus_aen` is high, `bus_ale` stays low, every strobe stays high and `req_ready` is low. `bus_aen` is low during processor cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_addr | input | 20 | Request address |
| req_wdata | input | 8 | Request write byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_ready | output | 1 | Request is taken at this edge if valid |
| rsp_done | output | 1 | One-clock cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| timeout_err | output | 1 | Sticky channel-ready timeout |
| dma_grant | input | 1 | DMA owns the bus when idle |
| bus_addr | output | 20 | Bus address, bit 0 least significant |
| bus_dout | output | 8 | Write byte to the bus |
| bus_dout_en | output | 1 | Drive enable for bus_dout |
| bus_din | input | 8 | Byte read from the bus |
| bus_ale | output | 1 | Address strobe, active high |
| bus_memr_n | output | 1 | Memory read strobe, active low |
| bus_memw_n | output | 1 | Memory write strobe, active low |
| bus_ior_n | output | 1 | I/O read strobe, active low |
| bus_iow_n | output | 1 | I/O write strobe, active low |
| bus_aen | output | 1 | Address enable, high while DMA owns the bus |
| bus_chrdy | input | 1 | Channel ready, low adds wait clocks |

## Verification
A fault in the command-clock or wait counter shows at once as a command strobe that stays low one clock too long or too short. It also moves `rsp_done` by the same amount within that cycle. A wrong kind register shows up in the first command clock as the wrong strobe being low. If the sequencer fails to return to idle, `req_ready` stays low in the clock after the recovery clock. A timeout counter that is off by one shows up only in cycles that have 10 or 11 low samples, so those counts are driven on purpose as well as reached at random.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_CMD   = 2'd2,
    ST_RECOV = 2'd3
  } bus_state_t;

  // Strobe index: bit1 = I/O space, bit0 = write.
  // 0 mem read, 1 mem write, 2 io read, 3 io write.
  function automatic logic [1:0] kind_of(input logic io, input logic write);
    return {io, write};
  endfunction

  // True once enough command clocks have passed for ready to count.
  function automatic logic sample_window(input int unsigned cmd_cnt,
                                         input int unsigned min_cmd);
    return (cmd_cnt + 1) >= min_cmd;
  endfunction

  // Command length for a given number of low ready samples.
  function automatic int unsigned cmd_clocks(input int unsigned lows,
                                             input int unsigned min_cmd,
                                             input int unsigned max_wait);
    return min_cmd + ((lows > max_wait) ? max_wait : lows);
  endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       finish,
  output bus_state_t state,
  output logic       ale,
  output logic       cmd_active,
  output logic       done
);

  bus_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start)  state_d = ST_ADDR;
      ST_ADDR:              state_d = ST_CMD;
      ST_CMD:   if (finish) state_d = ST_RECOV;
      ST_RECOV:             state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state      = state_q;
  assign ale        = (state_q == ST_ADDR);
  assign cmd_active = (state_q == ST_CMD);
  assign done       = (state_q == ST_RECOV);

  // R2
  ale_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  recov_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (state == ST_IDLE));

endmodule

// File: rtl/xbus_wait_timer.sv
module xbus_wait_timer
  import xbus_pkg::*;
#(
  parameter int unsigned MIN_CMD  = 2,
  parameter int unsigned MAX_WAIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_active,
  input  logic chrdy,
  output logic finish,
  output logic tmo_evt,
  output logic timeout_flag
);

  localparam int unsigned CMD_W  = $clog2(MIN_CMD + 1);
  localparam int unsigned WAIT_W = $clog2(MAX_WAIT + 1);

  logic [CMD_W-1:0]  cmd_cnt_q;
  logic [WAIT_W-1:0] wait_cnt_q;
  logic              tmo_q;
  logic              in_window;
  logic              wait_full;
  logic              low_sample;

  assign in_window  = cmd_active && sample_window(int'(cmd_cnt_q), MIN_CMD);
  assign wait_full  = (wait_cnt_q == WAIT_W'(MAX_WAIT));
  assign low_sample = in_window && !chrdy;
  assign tmo_evt    = low_sample && wait_full;
  assign finish     = in_window && (chrdy || wait_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_cnt_q  <= '0;
      wait_cnt_q <= '0;
    end else if (!cmd_active || finish) begin
      cmd_cnt_q  <= '0;
      wait_cnt_q <= '0;
    end else begin
      if (!in_window) cmd_cnt_q <= cmd_cnt_q + CMD_W'(1);
      if (low_sample) wait_cnt_q <= wait_cnt_q + WAIT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          tmo_q <= 1'b0;
    else if (tmo_evt) tmo_q <= 1'b1;
  end

  assign timeout_flag = tmo_q;

  // R6
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_flag |=> timeout_flag);

  // R6
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wait_cnt_q <= WAIT_W'(MAX_WAIT));

  // R5
  finish_cause_chk: assert property (@(posedge clk) disable iff (rst)
    finish |-> (chrdy || tmo_evt));

  // R4
  no_early_finish_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_active && $rose(cmd_active)) |-> !finish || (MIN_CMD <= 1));

endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec (
  input  logic [1:0] kind,
  input  logic       active,
  output logic       memr_n,
  output logic       memw_n,
  output logic       ior_n,
  output logic       iow_n
);

  localparam int unsigned NKIND = 4;

  logic [NKIND-1:0] low_vec;

  for (genvar k = 0; k < NKIND; k++) begin : g_strobe
    assign low_vec[k] = active && (kind == 2'(k));
  end

  assign memr_n = !low_vec[0];
  assign memw_n = !low_vec[1];
  assign ior_n  = !low_vec[2];
  assign iow_n  = !low_vec[3];

  // R3
  one_strobe_chk: assert final ($countones(low_vec) <= 1);

endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MIN_CMD  = 2,
  parameter int unsigned MAX_WAIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_io,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              timeout_err,
  input  logic              dma_grant,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_ale,
  output logic              bus_memr_n,
  output logic              bus_memw_n,
  output logic              bus_ior_n,
  output logic              bus_iow_n,
  output logic              bus_aen,
  input  logic              bus_chrdy
);

  bus_state_t        state;
  logic              start;
  logic              finish;
  logic              tmo_evt;
  logic              cmd_active;
  logic              ale;
  logic              done;
  logic              idle;
  logic              aen_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [1:0]        kind_q;
  logic              strobe_any_n;

  assign idle      = (state == ST_IDLE);
  assign req_ready = idle && !aen_q && !dma_grant;
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      kind_q  <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      kind_q  <= kind_of(req_io, req_write);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      rdata_q <= '0;
    else if (finish && !kind_q[0]) rdata_q <= bus_din;
  end

  always_ff @(posedge clk) begin
    if (rst) aen_q <= 1'b0;
    else     aen_q <= dma_grant && idle;
  end

  xbus_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .finish     (finish),
    .state      (state),
    .ale        (ale),
    .cmd_active (cmd_active),
    .done       (done)
  );

  xbus_wait_timer #(
    .MIN_CMD  (MIN_CMD),
    .MAX_WAIT (MAX_WAIT)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .cmd_active   (cmd_active),
    .chrdy        (bus_chrdy),
    .finish       (finish),
    .tmo_evt      (tmo_evt),
    .timeout_flag (timeout_err)
  );

  xbus_strobe_dec u_dec (
    .kind   (kind_q),
    .active (cmd_active),
    .memr_n (bus_memr_n),
    .memw_n (bus_memw_n),
    .ior_n  (bus_ior_n),
    .iow_n  (bus_iow_n)
  );

  assign bus_addr    = addr_q;
  assign bus_dout    = wdata_q;
  assign bus_dout_en = kind_q[0] && (ale || cmd_active);
  assign bus_ale     = ale;
  assign bus_aen     = aen_q;
  assign rsp_done    = done;
  assign rsp_rdata   = rdata_q;

  assign strobe_any_n = bus_memr_n && bus_memw_n && bus_ior_n && bus_iow_n;

  // R10
  aen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bus_aen |-> (!bus_ale && strobe_any_n && !req_ready));

  // R3
  no_strobe_in_ale_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> strobe_any_n);

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_any_n && !$rose(!strobe_any_n)) |-> $stable(bus_addr));

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ale || !strobe_any_n || rsp_done) |-> !req_ready);

  // R7
  done_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_done) |-> $past(!strobe_any_n));

endmodule

// File: tb/xbus_cycle_ctrl_bench.sv
module xbus_cycle_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_io = 1'b0;
  logic        req_ready;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic        timeout_err;
  logic        dma_grant = 1'b0;
  logic [19:0] bus_addr;
  logic [7:0]  bus_dout;
  logic        bus_dout_en;
  logic [7:0]  bus_din = '0;
  logic        bus_ale;
  logic        bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n;
  logic        bus_aen;
  logic        bus_chrdy = 1'b1;

  int checks = 0;
  int errors = 0;
  logic exp_tmo = 1'b0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  xbus_cycle_ctrl u_xbus_cycle_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .timeout_err(timeout_err), .dma_grant(dma_grant), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .bus_ale(bus_ale), .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
    .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_aen(bus_aen),
    .bus_chrdy(bus_chrdy)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n};
  endfunction

  // Expected {memr,memw,ior,iow} during command, one cold.
  function automatic logic [3:0] want_strobes(input logic io, input logic w);
    case ({io, w})
      2'b00:   return 4'b0111;
      2'b01:   return 4'b1011;
      2'b10:   return 4'b1101;
      default: return 4'b1110;
    endcase
  endfunction

  function automatic int want_cmd(input int lows);
    if (lows > 10) return 12;
    return 2 + lows;
  endfunction

  task automatic reset_check();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(strobes() == 4'hF, "R1 strobes", strobes(), 4'hF);
    chk(!bus_ale && !bus_aen && !rsp_done && !bus_dout_en, "R1 ctrl",
        {bus_ale, bus_aen, rsp_done, bus_dout_en}, 0);
    chk(!timeout_err, "R1 timeout", timeout_err, 0);
    rst = 1'b0;
    exp_tmo = 1'b0;
    @(negedge clk);
    chk(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic run_txn(input logic [19:0] a, input logic [7:0] wd,
                         input logic w, input logic io, input int lows,
                         input logic [7:0] din);
    int cmdcnt;
    bit seen;
    cmdcnt = 0;
    seen = 0;
    @(negedge clk);
    bus_din = din;
    bus_chrdy = 1'b1;
    req_addr = a; req_wdata = wd; req_write = w; req_io = io; req_valid = 1'b1;
    chk(req_ready, "R9 ready before", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_ale, "R2 ale", bus_ale, 1);
    chk(bus_addr == a, "R2 addr", bus_addr, a);
    chk(strobes() == 4'hF, "R3 none in ale", strobes(), 4'hF);
    chk(bus_dout_en == w, "R8 en addr clk", bus_dout_en, w);
    if (w) chk(bus_dout == wd, "R8 dout", bus_dout, wd);
    chk(!bus_aen, "R10 aen low", bus_aen, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rsp_done) begin
        seen = 1;
        break;
      end
      cmdcnt++;
      bus_chrdy = !(cmdcnt >= 2 && cmdcnt <= lows + 1);
      chk(!bus_ale, "R2 ale width", bus_ale, 0);
      chk(strobes() == want_strobes(io, w), "R3 strobe", strobes(), want_strobes(io, w));
      chk(bus_addr == a, "R2 addr hold", bus_addr, a);
      chk(bus_dout_en == w, "R8 en cmd", bus_dout_en, w);
      chk(!req_ready, "R9 busy", req_ready, 0);
    end
    bus_chrdy = 1'b1;
    if (lows > 10) exp_tmo = 1'b1;
    chk(seen, "R7 done seen", seen, 1);
    if (lows == 0) chk(cmdcnt == 2, "R4 base cycle", cmdcnt, 2);
    else if (lows > 10) chk(cmdcnt == 12, "R6 timeout length", cmdcnt, 12);
    else chk(cmdcnt == want_cmd(lows), "R5 wait clocks", cmdcnt, want_cmd(lows));
    chk(strobes() == 4'hF, "R7 recovery idle", strobes(), 4'hF);
    chk(!bus_dout_en, "R8 en off", bus_dout_en, 0);
    chk(!req_ready, "R9 recovery busy", req_ready, 0);
    chk(timeout_err == exp_tmo, "R6 flag", timeout_err, exp_tmo);
    if (!w) chk(rsp_rdata == din, "R7 rdata", rsp_rdata, din);
    @(negedge clk);
    chk(!rsp_done, "R7 done width", rsp_done, 0);
    chk(req_ready, "R9 ready again", req_ready, 1);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    reset_check();

    // Directed corners
    run_txn(20'hFFFFF, 8'hA5, 1'b0, 1'b0, 0, 8'h3C);   // R4 mem read
    run_txn(20'h00000, 8'h5A, 1'b1, 1'b0, 0, 8'h00);   // R3 mem write
    run_txn(20'h003F8, 8'h11, 1'b0, 1'b1, 1, 8'hC3);   // R5 io read
    run_txn(20'h00378, 8'h22, 1'b1, 1'b1, 3, 8'h00);   // R3 io write
    run_txn(20'h12345, 8'h00, 1'b0, 1'b0, 10, 8'h99);  // R6 edge, no timeout
    run_txn(20'h54321, 8'h77, 1'b0, 1'b1, 11, 8'h42);  // R6 timeout
    run_txn(20'hABCDE, 8'h88, 1'b1, 1'b0, 0, 8'h00);   // R6 flag stays
    reset_check();                                      // R1 clears flag

    // R10 DMA ownership
    @(negedge clk);
    dma_grant = 1'b1;
    req_valid = 1'b1;
    req_addr = 20'h0F0F0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(bus_aen, "R10 aen", bus_aen, 1);
      chk(!bus_ale && strobes() == 4'hF, "R10 quiet", {bus_ale, strobes()}, 4'hF);
      chk(!req_ready, "R10 ready", req_ready, 0);
    end
    dma_grant = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!bus_aen, "R10 release", bus_aen, 0);
    @(negedge clk);

    // Random mix
    for (int t = 0; t < 80; t++) begin
      int lw;
      lw = int'($urandom % 14);
      run_txn($urandom, 8'($urandom), 1'($urandom), 1'($urandom), lw, 8'($urandom));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule